// File: doc/BRIEF.md
# Oversampled SPI Slave Interface

This block is an SPI slave for mode 0 (SCK idles low, data is captured on the rising edge and changed on the falling edge). It runs entirely on a local system clock and never uses the serial clock as a clock. SCK and the active-low select are each passed through a two-flop synchronizer. The synchronized SCK is then delayed by one more register, and single-cycle rise and fall pulses are formed from the two copies. Those pulses act as enables for a receive shift register and a separate transmit shift register.

A two-state link machine follows the synchronized select. While the slave is deselected, the transmit register keeps reloading a parallel response word supplied by the user, and MISO is left in high impedance. While it is selected, MISO drives the top bit of the transmit register, and that register shifts left by one on every SCK falling edge. Each group of `W` SCK rising edges moves a complete received word to a parallel output and raises a one-cycle strobe. Several words may be sent within one select period.

Top module: `spi_os_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `rx_valid` is 0, `rx_word` is all zeros and MISO is high impedance.
- R2: SCK is sampled only through the synchronizer chain. Every SCK period whose high and low phases each last at least two system clocks records exactly one bit, whatever the duty cycle.
- R3: MOSI bits are captured on SCK rising edges, most significant bit first. After `W` captured bits, `rx_word` holds the word and `rx_valid` is 1.
- R4: Within one select period, consecutive groups of `W` rising edges each produce their own received word. Bit counting continues across the word boundary without a gap.
- R5: Deasserting select before `W` bits have arrived throws away the partial word without raising `rx_valid`. The next selection starts again from bit 0.
- R6: `rx_valid` stays high for exactly one system clock for each received word.
- R7: While deselected, the transmit register reloads `resp_word` on every system clock, so the value present when select falls is the value sent.
- R8: While selected, MISO presents `resp_word` most significant bit first and moves to the next bit after each SCK falling edge. Once all `W` bits have gone out, MISO sends zeros.
- R9: MISO is high impedance whenever the synchronized select is inactive.
- R10: Receive works with the system clock four times the SCK rate. MISO settles three system clocks after an SCK falling edge, so a master that samples MISO needs a half period of at least four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master (asynchronous) |
| cs_n | input | 1 | Active-low slave select (asynchronous) |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master; high impedance when deselected |
| resp_word | input | W | Parallel word to be sent on the next selection |
| rx_word | output | W | Last complete word received |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |

## Verification
The bench aborts a transfer after three bits and then sends a full word. A counter that is not cleared on deselect would join the two transfers into one wrong word, or raise a stray strobe. It sends two words in one selection, which catches a counter that stalls or drops a bit at the word boundary, and a transmit register that refills with anything other than zeros. It changes `resp_word` while the slave is idle, so a design that samples the response only once would send stale data. It runs at the 4:1 minimum rate, where a design with one synchronizer stage too many, or one that uses raw SCK, would miss or double-count bits. A pull-up on MISO shows whether the output is truly released when deselected.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;

    // Link state tracked from the synchronized select
    typedef enum logic [0:0] {
        LINK_IDLE  = 1'b0,
        LINK_SHIFT = 1'b1
    } link_state_e;

    // Edge information derived from the synchronized serial clock
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sck_event_t;

    // Reset values of the synchronized control lines
    localparam logic SCK_IDLE_LEVEL = 1'b0;
    localparam logic SEL_IDLE_LEVEL = 1'b1;

    function automatic logic edge_up(input logic now_lvl, input logic old_lvl);
        return now_lvl & ~old_lvl;
    endfunction

    function automatic logic edge_down(input logic now_lvl, input logic old_lvl);
        return ~now_lvl & old_lvl;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= RST_VAL;
                    else     stage[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= RST_VAL;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sck_edge_detect.sv
module sck_edge_detect
    import spi_os_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    output sck_event_t ev
);
    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= SCK_IDLE_LEVEL;
        else     lvl_d <= lvl;
    end

    always_comb begin
        ev.level = lvl;
        ev.rise  = edge_up(lvl, lvl_d);
        ev.fall  = edge_down(lvl, lvl_d);
    end
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
    parameter int W = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          rise,
    input  logic          din,
    output logic [W-1:0]  shreg,
    output logic [CW-1:0] bit_cnt,
    output logic [W-1:0]  word,
    output logic          valid
);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0] next_sh;

    assign next_sh = {shreg[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            word    <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
            end else if (rise) begin
                shreg <= next_sh;
                if (bit_cnt == LAST) begin
                    bit_cnt <= '0;
                    word    <= next_sh;
                    valid   <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         fall,
    input  logic [W-1:0] load_word,
    output logic [W-1:0] shreg
);
    always_ff @(posedge clk) begin
        if (rst)          shreg <= '0;
        else if (!active) shreg <= load_word;
        else if (fall)    shreg <= {shreg[W-2:0], 1'b0};
    end
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave
    import spi_os_pkg::*;
#(
    parameter int W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sck,
    input  logic         cs_n,
    input  logic         mosi,
    output logic         miso,
    input  logic [W-1:0] resp_word,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic        sck_s;
    logic        cs_n_s;
    logic        mosi_q;
    sck_event_t  sck_ev;
    link_state_e state;
    logic        active;
    logic [W-1:0]  rx_shreg;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  tx_reg;

    sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(SCK_IDLE_LEVEL)) u_sck_sync (
        .clk(clk), .rst(rst), .d(sck), .q(sck_s)
    );

    sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(SEL_IDLE_LEVEL)) u_sel_sync (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_n_s)
    );

    sck_edge_detect u_edge (
        .clk(clk), .rst(rst), .lvl(sck_s), .ev(sck_ev)
    );

    // single registered copy of MOSI, aligned with the delayed SCK
    always_ff @(posedge clk) begin
        if (rst) mosi_q <= 1'b0;
        else     mosi_q <= mosi;
    end

    // link state machine follows the synchronized select
    always_ff @(posedge clk) begin
        if (rst) state <= LINK_IDLE;
        else     state <= cs_n_s ? LINK_IDLE : LINK_SHIFT;
    end

    assign active = (state == LINK_SHIFT);

    spi_rx_shifter #(.W(W)) u_rx (
        .clk(clk), .rst(rst), .active(active), .rise(sck_ev.rise), .din(mosi_q),
        .shreg(rx_shreg), .bit_cnt(bit_cnt), .word(rx_word), .valid(rx_valid)
    );

    spi_tx_shifter #(.W(W)) u_tx (
        .clk(clk), .rst(rst), .active(active), .fall(sck_ev.fall),
        .load_word(resp_word), .shreg(tx_reg)
    );

    assign miso = active ? tx_reg[W-1] : 1'bz;
endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk #(
    parameter int W = 8,
    localparam int CW = (W > 1) ? $clog2(W) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          active,
    input logic          rise,
    input logic          fall,
    input logic [W-1:0]  resp_word,
    input logic [W-1:0]  tx_reg,
    input logic [W-1:0]  rx_shreg,
    input logic [CW-1:0] bit_cnt,
    input logic          rx_valid
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R6
    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (rst) rx_valid |-> $past(rise && active)); // R3
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst) !active |=> (bit_cnt == '0)); // R5
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst) !(active && rise) |=> $stable(rx_shreg)); // R2
    AST_TX_RELOAD: assert property (@(posedge clk) disable iff (rst) !active |=> (tx_reg == $past(resp_word))); // R7
    AST_TX_SHIFT: assert property (@(posedge clk) disable iff (rst) (active && fall) |=> (tx_reg == {$past(tx_reg[W-2:0]), 1'b0})); // R8
endmodule

bind spi_os_slave spi_os_slave_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .active(active), .rise(sck_ev.rise), .fall(sck_ev.fall),
    .resp_word(resp_word), .tx_reg(tx_reg), .rx_shreg(rx_shreg),
    .bit_cnt(bit_cnt), .rx_valid(rx_valid)
);

// File: tb/tb_spi_os_slave.sv
module tb_spi_os_slave;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sck = 1'b0;
    logic         cs_n = 1'b1;
    logic         mosi = 1'b0;
    logic [W-1:0] resp_word = '0;
    logic [W-1:0] rx_word;
    logic         rx_valid;
    wire          miso_w;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [W-1:0] rxq [$];

    pullup (miso_w);

    spi_os_slave #(.W(W)) dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso_w), .resp_word(resp_word), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always #5 clk = ~clk;

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // monitor: pop expected words on each strobe, and check the strobe is one cycle wide
    bit prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_valid) check({{(W-1){1'b0}}, rx_valid}, '0, "R6 strobe width");
            if (rx_valid) begin
                if (rxq.size() == 0) begin
                    check(rx_word, 'x, "R5 unexpected strobe");
                end else begin
                    check(rx_word, rxq.pop_front(), "R3 received word");
                end
            end
            prev_valid = rx_valid;
        end
    end

    // driver: one selection with up to two words, half period h system clocks
    task automatic frame(input logic [W-1:0] w0, input logic [W-1:0] w1, input int nbits,
                         input int h, input logic [W-1:0] resp, input bit chk_miso, input string req);
        logic [2*W-1:0] stream;
        logic [2*W-1:0] mexp;
        stream = {w0, w1};
        mexp   = {resp, {W{1'b0}}};
        if (nbits >= W)     rxq.push_back(w0);
        if (nbits >= 2 * W) rxq.push_back(w1);
        @(negedge clk);
        cs_n = 1'b0;
        mosi = stream[2*W-1];
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = stream[2*W-1-i];
            repeat (h) @(negedge clk);
            if (chk_miso) check({{(W-1){1'b0}}, miso_w}, {{(W-1){1'b0}}, mexp[2*W-1-i]}, req);
            sck = 1'b1;
            repeat (h) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(rx_word, '0, "R1 rx_word in reset");
        check({{(W-1){1'b0}}, rx_valid}, '0, "R1 rx_valid in reset");
        check({{(W-1){1'b0}}, miso_w}, {{(W-1){1'b0}}, 1'b1}, "R1 miso released");
        rst = 1'b0;
        @(negedge clk);
        check({{(W-1){1'b0}}, miso_w}, {{(W-1){1'b0}}, 1'b1}, "R1 miso after reset");

        // R3 / R8: basic word, both directions
        resp_word = 8'h3C;
        frame(8'hA5, 8'h00, W, 6, 8'h3C, 1'b1, "R8 miso bit");

        // R7: response changed while idle, latest value sent
        resp_word = 8'h11;
        repeat (4) @(negedge clk);
        resp_word = 8'hC9;
        frame(8'h5A, 8'h00, W, 4, 8'hC9, 1'b1, "R7 reloaded response");

        // R4: two words in one selection, zeros follow the response
        resp_word = 8'hF0;
        frame(8'h81, 8'h7E, 2 * W, 4, 8'hF0, 1'b1, "R4 back-to-back with zero fill R8");

        // R5: aborted partial word then a clean one
        frame(8'hFF, 8'h00, 3, 4, 8'hF0, 1'b0, "R5 abort");
        frame(8'h0F, 8'h00, W, 4, 8'hF0, 1'b0, "R5 restart");

        // R10 / R2: minimum 4:1 ratio and long phases
        frame(8'hC3, 8'h00, W, 2, 8'h00, 1'b0, "R10 fast");
        frame(8'h96, 8'h00, W, 9, 8'h00, 1'b0, "R2 slow");

        // R9: released while deselected, response MSB low
        resp_word = 8'h00;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check({{(W-1){1'b0}}, miso_w}, {{(W-1){1'b0}}, 1'b1}, "R9 miso high impedance");
        end

        repeat (10) @(negedge clk);
        check(W'(rxq.size()), '0, "R3 all words delivered");
        report();
    end
endmodule